// File: doc/BRIEF.md
# Plane Write Datapath with Read Latches

This block sits between the CPU data bus and a four-plane video memory. When the CPU writes a byte, the block builds one byte for each plane and a write enable for each plane. The CPU byte is rotated right, and each plane can replace it with all zeros or all ones from a per-plane set/reset pair. The result is combined with that plane's latch by a selectable logic operation. A bit mask then merges it with the latch one bit at a time. The memory is written only on planes that both the map mask and the address logic's plane enable allow.

The four latches are loaded on every CPU read with the bytes that memory returns for the four planes. Writes do not change them, so a read followed by masked writes can carry untouched pixels from the latched copy back into memory. Write results are registered. The per-plane data and enables appear on the clock after the write strobe, and the enables stay high for exactly that one cycle. The address mapping and the read path are handled by neighbouring blocks.

Top module: `plane_write_path`

## Requirements
- R1: After reset, `wr_en` is 0, `wr_data` is 0 and all four latches are 0, so a write whose bit mask is 0x00 produces 0x00 on every plane.
- R2: The CPU byte is rotated right by `cfg_rot` (0 to 7) before any other step; a bit leaving bit 0 re-enters at bit 7.
- R3: For plane p, if `cfg_sr_en[p]` is 1 the rotated byte is replaced by 0xFF when `cfg_sr_val[p]` is 1, or by 0x00 when it is 0; if `cfg_sr_en[p]` is 0 the rotated byte passes.
- R4: `cfg_op` selects the logic operation between that byte and plane p's latch: 0 passes the byte, 1 is AND, 2 is OR, 3 is XOR.
- R5: For each bit set in `cfg_bit_mask`, the plane's output bit comes from the logic result; for each clear bit, it comes from the plane's latch.
- R6: On a write, `wr_en[p]` is `cfg_map_mask[p] & addr_plane_en[p]`.
- R7: `wr_data` and `wr_en` change on the clock edge after the cycle in which `wr_stb` is high. `wr_en` is 0 in every cycle that does not follow a write strobe, and `wr_data` holds its last value in those cycles.
- R8: When `rd_stb` is high, plane p's latch loads `rd_plane_data[8p+7:8p]`. The latches change at no other time, and writes leave them unchanged.
- R9: When `rd_stb` and `wr_stb` are high in the same cycle, the write uses the latch values from before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| wr_stb | input | 1 | CPU write strobe, one cycle per byte |
| rd_stb | input | 1 | CPU read strobe; loads the latches |
| cpu_wdata | input | 8 | CPU write byte |
| rd_plane_data | input | 32 | Bytes read from the planes; plane p is in bits [8p+7:8p] |
| addr_plane_en | input | 4 | Plane enable from the address logic |
| cfg_rot | input | 3 | Rotate-right count |
| cfg_op | input | 2 | Logic operation: 0 pass, 1 AND, 2 OR, 3 XOR |
| cfg_sr_val | input | 4 | Per-plane set/reset value |
| cfg_sr_en | input | 4 | Per-plane set/reset enable |
| cfg_bit_mask | input | 8 | Bit mask: 1 takes the logic result, 0 takes the latch |
| cfg_map_mask | input | 4 | Per-plane write mask |
| wr_data | output | 32 | Registered data for each plane, same packing as rd_plane_data |
| wr_enable | output | 4 | Registered per-plane write enable |

## Verification
A CPU read and a CPU write can arrive in the same cycle. In that cycle the latch load and the write's logic operation and mask merge both involve the latches. The bench first loads known latch values and then raises both strobes in one cycle, with new read data and a write whose bit mask is partial. It judges the written bytes against the older latch values. A following write with a zero bit mask must then return the newly read bytes.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  parameter int unsigned PLANES = 4;
  parameter int unsigned DW     = 8;
  localparam int unsigned RW    = $clog2(DW);

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_XOR  = 2'd3
  } alu_op_e;
endpackage

// File: rtl/pwp_rst_sync.sv
module pwp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pwp_rotator.sv
module pwp_rotator #(
  parameter int unsigned DW = 8,
  localparam int unsigned RW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [RW-1:0] amount,
  output logic [DW-1:0] dout
);
  logic [2*DW-1:0] doubled;

  always_comb begin
    doubled = {din, din} >> amount;
    dout    = doubled[DW-1:0];
  end
endmodule

// File: rtl/pwp_lane.sv
module pwp_lane
  import pwp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] rot_byte,
  input  logic          sr_en,
  input  logic          sr_val,
  input  logic [1:0]    op,
  input  logic [DW-1:0] bit_mask,
  input  logic [DW-1:0] latch,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] src;
  logic [DW-1:0] alu;
  alu_op_e       op_e;

  always_comb begin
    src  = sr_en ? {DW{sr_val}} : rot_byte;
    op_e = alu_op_e'(op);
    unique case (op_e)
      OP_AND:  alu = src & latch;
      OP_OR:   alu = src | latch;
      OP_XOR:  alu = src ^ latch;
      default: alu = src;
    endcase
    dout = (alu & bit_mask) | (latch & ~bit_mask);
  end
endmodule

// File: rtl/pwp_latch_bank.sv
module pwp_latch_bank #(
  parameter int unsigned PLANES = 4,
  parameter int unsigned DW     = 8,
  localparam int unsigned TW    = PLANES*DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] din,
  output logic [TW-1:0] lat
);
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [DW-1:0] lat_q;
    logic [DW-1:0] lat_d;

    always_comb begin
      lat_d = lat_q;
      if (load) lat_d = din[p*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= lat_d;
    end

    assign lat[p*DW +: DW] = lat_q;
  end
endmodule

// File: rtl/plane_write_path.sv
module plane_write_path
  import pwp_pkg::*;
#(
  parameter int unsigned NP = PLANES,
  parameter int unsigned BW = DW,
  localparam int unsigned TW = NP*BW,
  localparam int unsigned CW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [BW-1:0] cpu_wdata,
  input  logic [TW-1:0] rd_plane_data,
  input  logic [NP-1:0] addr_plane_en,
  input  logic [CW-1:0] cfg_rot,
  input  logic [1:0]    cfg_op,
  input  logic [NP-1:0] cfg_sr_val,
  input  logic [NP-1:0] cfg_sr_en,
  input  logic [BW-1:0] cfg_bit_mask,
  input  logic [NP-1:0] cfg_map_mask,
  output logic [TW-1:0] wr_data,
  output logic [NP-1:0] wr_enable
);
  logic          rst_sync_n;
  logic [BW-1:0] rot_byte;
  logic [TW-1:0] lat_q;
  logic [TW-1:0] lane_data;
  logic [TW-1:0] wdata_q, wdata_d;
  logic [NP-1:0] wen_q, wen_d;

  pwp_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pwp_rotator #(.DW(BW)) u_rot (
    .din(cpu_wdata), .amount(cfg_rot), .dout(rot_byte)
  );

  pwp_latch_bank #(.PLANES(NP), .DW(BW)) u_lat (
    .clk(clk), .rst_n(rst_sync_n), .load(rd_stb),
    .din(rd_plane_data), .lat(lat_q)
  );

  for (genvar p = 0; p < NP; p++) begin : g_lane
    pwp_lane #(.DW(BW)) u_lane (
      .rot_byte(rot_byte),
      .sr_en(cfg_sr_en[p]),
      .sr_val(cfg_sr_val[p]),
      .op(cfg_op),
      .bit_mask(cfg_bit_mask),
      .latch(lat_q[p*BW +: BW]),
      .dout(lane_data[p*BW +: BW])
    );
  end

  // next-state: data register has a write clock enable, enables pulse
  always_comb begin
    wdata_d = wdata_q;
    wen_d   = '0;
    if (wr_stb) begin
      wdata_d = lane_data;
      wen_d   = cfg_map_mask & addr_plane_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wdata_q <= '0;
      wen_q   <= '0;
    end else begin
      wdata_q <= wdata_d;
      wen_q   <= wen_d;
    end
  end

  assign wr_data   = wdata_q;
  assign wr_enable = wen_q;
endmodule

// File: rtl/pwp_checker.sv
module pwp_checker #(
  parameter int unsigned NP = 4,
  parameter int unsigned BW = 8,
  localparam int unsigned TW = NP*BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic [TW-1:0] rd_plane_data,
  input logic [NP-1:0] addr_plane_en,
  input logic [NP-1:0] cfg_map_mask,
  input logic [BW-1:0] cfg_bit_mask,
  input logic [TW-1:0] lat,
  input logic [TW-1:0] wr_data,
  input logic [NP-1:0] wr_enable
);
  AST_EN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stb) |-> wr_enable == ($past(cfg_map_mask) & $past(addr_plane_en))); // R6

  AST_EN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> wr_enable == '0); // R7

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stb) |-> $stable(wr_data)); // R7

  AST_MASK_ZERO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_stb) && $past(cfg_bit_mask) == '0) |-> wr_data == $past(lat)); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_stb) |-> $stable(lat)); // R8

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stb) |-> lat == $past(rd_plane_data)); // R8
endmodule

bind plane_write_path pwp_checker #(.NP(NP), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .rd_plane_data(rd_plane_data), .addr_plane_en(addr_plane_en),
  .cfg_map_mask(cfg_map_mask), .cfg_bit_mask(cfg_bit_mask),
  .lat(lat_q), .wr_data(wr_data), .wr_enable(wr_enable)
);

// File: tb/plane_write_path_tb.sv
module plane_write_path_tb_top;
  localparam int NP = 4;
  localparam int BW = 8;
  localparam int TW = NP*BW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_stb, rd_stb;
  logic [BW-1:0] cpu_wdata;
  logic [TW-1:0] rd_plane_data;
  logic [NP-1:0] addr_plane_en;
  logic [2:0]    cfg_rot;
  logic [1:0]    cfg_op;
  logic [NP-1:0] cfg_sr_val, cfg_sr_en, cfg_map_mask;
  logic [BW-1:0] cfg_bit_mask;
  logic [TW-1:0] wr_data;
  logic [NP-1:0] wr_enable;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;
  logic [BW-1:0] mlat [NP];

  typedef struct {
    int            due;
    logic [TW-1:0] data;
    logic [NP-1:0] en;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  plane_write_path dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .cpu_wdata(cpu_wdata), .rd_plane_data(rd_plane_data),
    .addr_plane_en(addr_plane_en), .cfg_rot(cfg_rot), .cfg_op(cfg_op),
    .cfg_sr_val(cfg_sr_val), .cfg_sr_en(cfg_sr_en),
    .cfg_bit_mask(cfg_bit_mask), .cfg_map_mask(cfg_map_mask),
    .wr_data(wr_data), .wr_enable(wr_enable)
  );

  function automatic logic [TW-1:0] model_data();
    logic [TW-1:0] r;
    logic [BW-1:0] rot, s, a, l;
    rot = BW'((({cpu_wdata, cpu_wdata}) >> cfg_rot));
    for (int p = 0; p < NP; p++) begin
      l = mlat[p];
      s = cfg_sr_en[p] ? (cfg_sr_val[p] ? 8'hFF : 8'h00) : rot;
      case (cfg_op)
        2'd1:    a = s & l;
        2'd2:    a = s | l;
        2'd3:    a = s ^ l;
        default: a = s;
      endcase
      r[p*BW +: BW] = (a & cfg_bit_mask) | (l & ~cfg_bit_mask);
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: one write strobe, expected items pushed to scoreboard
  task automatic do_write(string req, bit with_read, logic [TW-1:0] rdata, bit idle_chk);
    exp_t e;
    @(negedge clk);
    wr_stb = 1'b1;
    rd_stb = with_read;
    rd_plane_data = rdata;
    e.due  = cyc + 1;
    e.data = model_data();
    e.en   = cfg_map_mask & addr_plane_en;
    e.req  = req;
    sb.push_back(e);
    if (idle_chk) begin
      e.due = cyc + 2;
      e.en  = '0;
      e.req = "R7";
      sb.push_back(e);
    end
    if (with_read)
      for (int p = 0; p < NP; p++) mlat[p] = rdata[p*BW +: BW];
    @(negedge clk);
    wr_stb = 1'b0;
    rd_stb = 1'b0;
  endtask

  task automatic do_read(logic [TW-1:0] rdata);
    @(negedge clk);
    rd_stb = 1'b1;
    rd_plane_data = rdata;
    for (int p = 0; p < NP; p++) mlat[p] = rdata[p*BW +: BW];
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic cfg(logic [2:0] rot, logic [1:0] op, logic [3:0] sre,
                     logic [3:0] srv, logic [7:0] bm, logic [3:0] mm,
                     logic [3:0] pe, logic [7:0] d);
    cfg_rot = rot; cfg_op = op; cfg_sr_en = sre; cfg_sr_val = srv;
    cfg_bit_mask = bm; cfg_map_mask = mm; addr_plane_en = pe; cpu_wdata = d;
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check({e.req, " data"}, 64'(wr_data), 64'(e.data));
      check({e.req, " enable"}, 64'(wr_enable), 64'(e.en));
    end
  end

  initial begin
    rst_n = 1'b0; wr_stb = 0; rd_stb = 0; rd_plane_data = '0;
    cfg(3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 4'hF, 4'hF, 8'h00);
    for (int p = 0; p < NP; p++) mlat[p] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset enable", 64'(wr_enable), 64'h0);
    check("R1 reset data", 64'(wr_data), 64'h0);
    // R1: zero latches through a zero bit mask
    cfg(3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 4'hF, 4'hF, 8'hFF);
    do_write("R1", 0, '0, 1);
    // R8: load latches
    do_read(32'h0F_F0_3C_A5);
    // R4 pass, full mask
    cfg(3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 4'hF, 8'h81);
    do_write("R4", 0, '0, 1);
    // R2 rotations
    cfg(3'd3, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 4'hF, 8'h81);
    do_write("R2", 0, '0, 1);
    cfg(3'd1, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 4'hF, 8'h01);
    do_write("R2", 0, '0, 1);
    cfg(3'd7, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 4'hF, 8'h80);
    do_write("R2", 0, '0, 1);
    // R3 set/reset override
    cfg(3'd0, 2'd0, 4'h5, 4'h1, 8'hFF, 4'hF, 4'hF, 8'h5A);
    do_write("R3", 0, '0, 1);
    cfg(3'd2, 2'd3, 4'hA, 4'hA, 8'hFF, 4'hF, 4'hF, 8'h33);
    do_write("R3", 0, '0, 1);
    // R4 logic ops, back to back (R7)
    cfg(3'd0, 2'd1, 4'h0, 4'h0, 8'hFF, 4'hF, 4'hF, 8'h6E);
    do_write("R4", 0, '0, 0);
    cfg(3'd0, 2'd2, 4'h0, 4'h0, 8'hFF, 4'hF, 4'hF, 8'h6E);
    do_write("R4", 0, '0, 0);
    cfg(3'd0, 2'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 4'hF, 8'h6E);
    do_write("R4", 0, '0, 1);
    // R5 bit mask merge
    cfg(3'd0, 2'd0, 4'h0, 4'h0, 8'h0F, 4'hF, 4'hF, 8'hC3);
    do_write("R5", 0, '0, 1);
    cfg(3'd4, 2'd3, 4'h1, 4'h1, 8'hA5, 4'hF, 4'hF, 8'h12);
    do_write("R5", 0, '0, 1);
    // R6 enable gating
    cfg(3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hC, 4'h6, 8'h99);
    do_write("R6", 0, '0, 1);
    cfg(3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'h3, 4'hC, 8'h99);
    do_write("R6", 0, '0, 1);
    // R8: latches unchanged by the writes above
    cfg(3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 4'hF, 4'hF, 8'hFF);
    do_write("R8", 0, '0, 1);
    // R9: simultaneous read and write uses old latches
    cfg(3'd0, 2'd3, 4'h0, 4'h0, 8'hF0, 4'hF, 4'hF, 8'hFF);
    do_write("R9", 1, 32'h11_22_33_44, 1);
    cfg(3'd0, 2'd0, 4'h0, 4'h0, 8'h00, 4'hF, 4'hF, 8'h00);
    do_write("R8", 0, '0, 1);
    repeat (4) @(negedge clk);
    check("R7 scoreboard drained", 64'(sb.size()), 64'h0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule